// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block decides, cycle by cycle, what each of four differential clock output pairs and one single-ended reference output should be doing. A pair either carries the free-running source clock, as a true/complement pair, or sits in a programmed stop state. The decision combines the per-pair enable pins, a per-pair software enable, the PLL lock flag and a combined power-good/power-down pin. The analog drivers, the PLL and register access live elsewhere. This block only produces the logical true/complement values and a Hi-Z flag per pair.

The first time the power pin reaches its run level, the block starts and captures the strap inputs. From then on the same pin only moves the block in and out of power-down, and the strap copy never changes again. The reference output is Hi-Z until that first start. After start it follows its own enable, and a wake bit can keep it running through power-down. The enable pins and the power pin pass through two-flop synchronisers. Each output's run state is updated only at a falling edge of the source clock, so no output ever shows a shortened high phase.

Top module: `ckout_ctrl`

## Requirements
- R1: While `pll_locked` is 0, every pair is in its stop state.
- R2: `started` goes to 1 after the power pin is first seen at its run level, and then stays at 1 until reset. `strap_q` captures `strap_pin` at that moment and holds it through any later power-down cycles. While `started` is 0, every pair is in its stop state.
- R3: When `pair_en_pol_hi[i]`=0, a 0 on `pair_en_pin[i]` enables pair i and a 1 disables it. When `pair_en_pol_hi[i]`=1, the pin's sense is inverted.
- R4: When `pair_sw_en[i]`=0, pair i is forced to its stop state whatever the level of its pin.
- R5: Pair i's stop code is `pair_stop_code[2i+1:2i]`, and it sets the outputs as follows:
  - 00 gives t=0, c=0.
  - 01 gives Hi-Z, with `pair_hiz`=1 and t=c=0.
  - 10 gives t=1, c=0.
  - 11 gives t=0, c=1.
  
  A running pair drives t=clk and c=~clk, with `pair_hiz`=0.
- R6: After start, the power pin at its power-down level stops every pair, and returning it to the run level restarts them. The power-down level is low when `pwr_pol_hi`=0 and high when `pwr_pol_hi`=1.
- R7: Before start, `ref_hiz`=1 and `ref_clk_o`=0. After start, `ref_hiz`=0, and the reference runs when `ref_sw_en`=1 and either the block is out of power-down or `ref_wake_run`=1. Otherwise it is held low.
- R8: Suppose an enable pin changes just after a falling edge. The pair's output then follows the change from the third rising edge after it, and a run state changes only while clk is low.
- R9: `cfg_clear` is 1 exactly while the block is in power-down with `keep_cfg_pd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_en_pin | input | NUM_PAIRS | Raw per-pair enable pins |
| pwr_pin | input | 1 | Raw power-good / power-down pin |
| pll_locked | input | 1 | PLL lock flag, synchronous to clk |
| strap_pin | input | STRAP_W | Strap inputs captured at start |
| pair_sw_en | input | NUM_PAIRS | Per-pair software enable (0 forces stop) |
| pair_en_pol_hi | input | NUM_PAIRS | Per-pair pin polarity (1 = enabled when high) |
| pwr_pol_hi | input | 1 | Power pin polarity (1 = power-down when high) |
| pair_stop_code | input | 2*NUM_PAIRS | Per-pair stop-state codes |
| ref_sw_en | input | 1 | Reference output enable |
| ref_wake_run | input | 1 | Keep reference running in power-down |
| keep_cfg_pd | input | 1 | 1 = configuration kept through power-down |
| pair_t | output | NUM_PAIRS | True output value per pair |
| pair_c | output | NUM_PAIRS | Complement output value per pair |
| pair_hiz | output | NUM_PAIRS | Hi-Z flag per pair |
| ref_clk_o | output | 1 | Reference output value |
| ref_hiz | output | 1 | Reference Hi-Z flag |
| started | output | 1 | First power-good assertion has happened |
| strap_q | output | STRAP_W | Captured strap value |
| cfg_clear | output | 1 | Request to return configuration to defaults |

## Verification
The hardest situation to reach from the ports is a second or third power-good edge, where the straps must not be captured again. The stimulus reaches it by starting the block, changing `strap_pin`, and then taking the power pin through a full power-down and exit before reading `strap_q`. The enable latency is also delicate, because it is exact to the edge. Each enable pin is therefore toggled just after a falling edge, and the true output is sampled in the high phase of each of the next three rising edges. This shows that the switch lands on the third edge and never inside a high phase.

// File: rtl/ckout_pkg.sv
package ckout_pkg;

    localparam int STOP_W = 2;

    typedef enum logic [STOP_W-1:0] {
        STOP_LOW_LOW  = 2'b00,
        STOP_HIZ      = 2'b01,
        STOP_HIGH_LOW = 2'b10,
        STOP_LOW_HIGH = 2'b11
    } stop_code_e;

    typedef struct packed {
        logic t;
        logic c;
        logic hiz;
    } pin_drive_t;

    function automatic pin_drive_t stop_drive(input logic [STOP_W-1:0] code);
        pin_drive_t d;
        d = '0;
        case (stop_code_e'(code))
            STOP_HIZ:      d.hiz = 1'b1;
            STOP_HIGH_LOW: d.t   = 1'b1;
            STOP_LOW_HIGH: d.c   = 1'b1;
            default:       d     = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ckout_sync.sv
module ckout_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;

endmodule

// File: rtl/ckout_gate.sv
module ckout_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic run
);

    logic run_d, run_q;

    always_comb begin
        run_d = want;
    end

    // Captured at the falling edge: the gate only moves while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign run = run_q;

endmodule

// File: rtl/ckout_ctrl.sv
module ckout_ctrl
    import ckout_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int STRAP_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PAIRS-1:0]        pair_en_pin,
    input  logic                        pwr_pin,
    input  logic                        pll_locked,
    input  logic [STRAP_W-1:0]          strap_pin,
    input  logic [NUM_PAIRS-1:0]        pair_sw_en,
    input  logic [NUM_PAIRS-1:0]        pair_en_pol_hi,
    input  logic                        pwr_pol_hi,
    input  logic [NUM_PAIRS*STOP_W-1:0] pair_stop_code,
    input  logic                        ref_sw_en,
    input  logic                        ref_wake_run,
    input  logic                        keep_cfg_pd,
    output logic [NUM_PAIRS-1:0]        pair_t,
    output logic [NUM_PAIRS-1:0]        pair_c,
    output logic [NUM_PAIRS-1:0]        pair_hiz,
    output logic                        ref_clk_o,
    output logic                        ref_hiz,
    output logic                        started,
    output logic [STRAP_W-1:0]          strap_q,
    output logic                        cfg_clear
);

    localparam int SYNC_W = NUM_PAIRS + 1;

    typedef struct packed {
        logic               started;
        logic [STRAP_W-1:0] strap;
    } ctl_t;

    ctl_t                 ctl_d, ctl_q;
    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_PAIRS-1:0] en_s;
    logic                 pwr_s;
    logic                 pwr_run_lvl;
    logic                 in_pd;
    logic                 live;
    logic [NUM_PAIRS-1:0] pin_on;
    logic [NUM_PAIRS-1:0] pair_want;
    logic [NUM_PAIRS-1:0] pair_run;
    logic                 ref_want;
    logic                 ref_run;

    ckout_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pwr_pin, pair_en_pin}),
        .sync_out (sync_out)
    );

    assign en_s  = sync_out[NUM_PAIRS-1:0];
    assign pwr_s = sync_out[NUM_PAIRS];

    always_comb begin
        ctl_d       = ctl_q;
        pwr_run_lvl = pwr_pol_hi ? ~pwr_s : pwr_s;
        if (!ctl_q.started && pwr_run_lvl) begin
            ctl_d.started = 1'b1;
            ctl_d.strap   = strap_pin;
        end
        in_pd = ctl_q.started & ~pwr_run_lvl;
        live  = ctl_q.started & ~in_pd & pll_locked;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            pin_on[i]    = pair_en_pol_hi[i] ? en_s[i] : ~en_s[i];
            pair_want[i] = live & pair_sw_en[i] & pin_on[i];
        end
        ref_want = ctl_q.started & ref_sw_en & (~in_pd | ref_wake_run);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        pin_drive_t stop;

        ckout_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (pair_want[g]),
            .run   (pair_run[g])
        );

        assign stop        = stop_drive(pair_stop_code[g*STOP_W +: STOP_W]);
        assign pair_t[g]   = pair_run[g] ? clk  : stop.t;
        assign pair_c[g]   = pair_run[g] ? ~clk : stop.c;
        assign pair_hiz[g] = ~pair_run[g] & stop.hiz;
    end

    ckout_gate u_ref_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (ref_want),
        .run   (ref_run)
    );

    assign ref_clk_o = ref_run & clk;
    assign ref_hiz   = ~ctl_q.started;
    assign started   = ctl_q.started;
    assign strap_q   = ctl_q.strap;
    assign cfg_clear = in_pd & ~keep_cfg_pd;

endmodule

// File: rtl/ckout_ctrl_chk.sv
module ckout_ctrl_chk #(
    parameter int NUM_PAIRS = 4,
    parameter int STRAP_W   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pll_locked,
    input logic [NUM_PAIRS-1:0] pair_sw_en,
    input logic [NUM_PAIRS-1:0] pair_hiz,
    input logic [NUM_PAIRS-1:0] pair_run,
    input logic                 ref_hiz,
    input logic                 ref_clk_o,
    input logic                 started,
    input logic [STRAP_W-1:0]   strap_q
);

    assert_lock_hold_R1: assert property (@(negedge clk) disable iff (!rst_n)
        !pll_locked |=> (pair_run == '0));

    assert_start_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> started);

    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(started)) |-> $stable(strap_q));

    assert_no_run_unstarted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (pair_run == '0));

    assert_sw_override_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (pair_sw_en != '1) |=> ((pair_run & ~$past(pair_sw_en)) == '0));

    assert_hiz_only_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_hiz & pair_run) == '0);

    assert_ref_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (ref_hiz && !ref_clk_o));

endmodule

bind ckout_ctrl ckout_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS), .STRAP_W(STRAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_locked (pll_locked),
    .pair_sw_en (pair_sw_en),
    .pair_hiz   (pair_hiz),
    .pair_run   (pair_run),
    .ref_hiz    (ref_hiz),
    .ref_clk_o  (ref_clk_o),
    .started    (started),
    .strap_q    (strap_q)
);

// File: tb/tb_ckout_ctrl.sv
`timescale 1ns/1ps
module tb_ckout_ctrl;

    localparam int NP = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pair_en_pin = '0;
    logic          pwr_pin = 1'b0;
    logic          pll_locked = 1'b0;
    logic [SW-1:0] strap_pin = 2'b10;
    logic [NP-1:0] pair_sw_en = '1;
    logic [NP-1:0] pair_en_pol_hi = '0;
    logic          pwr_pol_hi = 1'b0;
    logic [2*NP-1:0] pair_stop_code = '0;
    logic          ref_sw_en = 1'b1;
    logic          ref_wake_run = 1'b0;
    logic          keep_cfg_pd = 1'b1;
    logic [NP-1:0] pair_t, pair_c, pair_hiz;
    logic          ref_clk_o, ref_hiz, started, cfg_clear;
    logic [SW-1:0] strap_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ckout_ctrl #(.NUM_PAIRS(NP), .STRAP_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .pair_en_pin(pair_en_pin), .pwr_pin(pwr_pin),
        .pll_locked(pll_locked), .strap_pin(strap_pin), .pair_sw_en(pair_sw_en),
        .pair_en_pol_hi(pair_en_pol_hi), .pwr_pol_hi(pwr_pol_hi),
        .pair_stop_code(pair_stop_code), .ref_sw_en(ref_sw_en),
        .ref_wake_run(ref_wake_run), .keep_cfg_pd(keep_cfg_pd),
        .pair_t(pair_t), .pair_c(pair_c), .pair_hiz(pair_hiz),
        .ref_clk_o(ref_clk_o), .ref_hiz(ref_hiz), .started(started),
        .strap_q(strap_q), .cfg_clear(cfg_clear)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
        #1;
    endtask

    // {t_high, c_high, t_low, c_low, hiz}; ends just after a falling edge
    task automatic expect_pair(input int i, input bit run, input logic [1:0] code, input string tag);
        logic [4:0] got, exp;
        @(posedge clk); #1;
        got[4] = pair_t[i]; got[3] = pair_c[i];
        @(negedge clk); #1;
        got[2] = pair_t[i]; got[1] = pair_c[i]; got[0] = pair_hiz[i];
        if (run) exp = 5'b10010;
        else case (code)
            2'b00:   exp = 5'b00000;
            2'b01:   exp = 5'b00001;
            2'b10:   exp = 5'b10100;
            default: exp = 5'b01010;
        endcase
        chk(tag, 32'(got), 32'(exp));
    endtask

    task automatic expect_ref(input bit run, input bit hiz, input string tag);
        logic [2:0] got;
        @(posedge clk); #1;
        got[2] = ref_clk_o;
        @(negedge clk); #1;
        got[1] = ref_clk_o; got[0] = ref_hiz;
        chk(tag, 32'(got), run ? 32'b100 : 32'({2'b00, hiz}));
    endtask

    task automatic t_reset();
        chk("R2 reset started", 32'(started), 0);
        chk("R7 reset ref hiz", 32'(ref_hiz), 1);
        expect_pair(0, 0, 2'b00, "R5 reset pair0 low/low");
        expect_ref(0, 1, "R7 ref hiz before start");
    endtask

    task automatic t_prestart_r2();
        pll_locked = 1'b1;
        pair_stop_code[1:0] = 2'b10;
        settle();
        chk("R2 not started", 32'(started), 0);
        expect_pair(0, 0, 2'b10, "R2 pair held before start");
        pair_stop_code[1:0] = 2'b00;
    endtask

    task automatic t_start_r2();
        pwr_pin = 1'b1;
        settle();
        chk("R2 started set", 32'(started), 1);
        chk("R2 strap captured", 32'(strap_q), 32'(2'b10));
        for (int i = 0; i < NP; i++) expect_pair(i, 1, 2'b00, "R2 pair runs after start");
        expect_ref(1, 0, "R7 ref runs after start");
    endtask

    task automatic t_lock_r1();
        pll_locked = 1'b0;
        pair_stop_code[3:2] = 2'b11;
        settle();
        expect_pair(0, 0, 2'b00, "R1 unlocked pair0 stop");
        expect_pair(1, 0, 2'b11, "R1 unlocked pair1 stop");
        pair_stop_code[3:2] = 2'b00;
        pll_locked = 1'b1;
        settle();
        expect_pair(1, 1, 2'b00, "R1 relock pair1 runs");
    endtask

    task automatic t_latency_r8();
        logic [3:0] seen;
        seen = '0;
        pair_en_pin[1] = 1'b1;
        for (int k = 1; k <= 3; k++) begin @(posedge clk); #1; seen[k] = pair_t[1]; end
        chk("R8 still running at edge 2", 32'(seen[2]), 1);
        chk("R8 stopped at edge 3", 32'(seen[3]), 0);
        @(negedge clk); #1;
        pair_en_pin[1] = 1'b0;
        for (int k = 1; k <= 3; k++) begin @(posedge clk); #1; seen[k] = pair_t[1]; end
        chk("R8 still stopped at edge 2", 32'(seen[2]), 0);
        chk("R8 running at edge 3", 32'(seen[3]), 1);
        @(negedge clk); #1;
    endtask

    task automatic t_polarity_r3();
        pair_en_pin[1] = 1'b1;
        settle();
        expect_pair(1, 0, 2'b00, "R3 pin high disables active-low pair");
        pair_en_pol_hi[2] = 1'b1;
        pair_en_pin[2] = 1'b0;
        settle();
        expect_pair(2, 0, 2'b00, "R3 pol_hi pin low disables");
        pair_en_pin[2] = 1'b1;
        settle();
        expect_pair(2, 1, 2'b00, "R3 pol_hi pin high enables");
        pair_en_pin[1] = 1'b0;
    endtask

    task automatic t_override_r4();
        pair_sw_en[3] = 1'b0;
        pair_stop_code[7:6] = 2'b11;
        settle();
        expect_pair(3, 0, 2'b11, "R4 sw disable overrides enabled pin");
        pair_sw_en[3] = 1'b1;
        settle();
        expect_pair(3, 1, 2'b11, "R4 sw enable gives pin control");
    endtask

    task automatic t_codes_r5();
        pair_sw_en[0] = 1'b0;
        for (int cd = 0; cd < 4; cd++) begin
            pair_stop_code[1:0] = 2'(cd);
            settle();
            expect_pair(0, 0, 2'(cd), $sformatf("R5 stop code %0d", cd));
        end
        pair_stop_code[1:0] = 2'b00;
        pair_sw_en[0] = 1'b1;
        settle();
    endtask

    task automatic t_pd_r6();
        strap_pin = 2'b01;
        pwr_pin = 1'b0;
        settle();
        chk("R6 started held in pd", 32'(started), 1);
        expect_pair(0, 0, 2'b00, "R6 pd stops pair0");
        expect_pair(3, 0, 2'b11, "R6 pd stops pair3");
        pwr_pin = 1'b1;
        settle();
        expect_pair(0, 1, 2'b00, "R6 pd exit restarts pair0");
        chk("R2 strap not recaptured", 32'(strap_q), 32'(2'b10));
        pwr_pol_hi = 1'b1;
        settle();
        expect_pair(0, 0, 2'b00, "R6 active-high pd stops pair0");
        pwr_pol_hi = 1'b0;
        settle();
        expect_pair(0, 1, 2'b00, "R6 polarity back runs pair0");
    endtask

    task automatic t_ref_r7();
        ref_sw_en = 1'b0;
        settle();
        expect_ref(0, 0, "R7 ref disabled low");
        ref_sw_en = 1'b1;
        pwr_pin = 1'b0;
        settle();
        expect_ref(0, 0, "R7 ref low in pd without wake");
        ref_wake_run = 1'b1;
        settle();
        expect_ref(1, 0, "R7 ref runs in pd with wake");
        ref_wake_run = 1'b0;
        pwr_pin = 1'b1;
        settle();
        expect_ref(1, 0, "R7 ref runs after pd exit");
    endtask

    task automatic t_cfgclr_r9();
        chk("R9 no clear out of pd", 32'(cfg_clear), 0);
        keep_cfg_pd = 1'b0;
        #1;
        chk("R9 no clear out of pd keep=0", 32'(cfg_clear), 0);
        pwr_pin = 1'b0;
        settle();
        chk("R9 clear in pd keep=0", 32'(cfg_clear), 1);
        keep_cfg_pd = 1'b1;
        #1;
        chk("R9 no clear in pd keep=1", 32'(cfg_clear), 0);
        pwr_pin = 1'b1;
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_prestart_r2();
        t_start_r2();
        t_lock_r1();
        t_latency_r8();
        t_polarity_r3();
        t_override_r4();
        t_codes_r5();
        t_pd_r6();
        t_ref_r7();
        t_cfgclr_r9();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule